// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs transactions on a two-wire PHY management bus. The host supplies a one-cycle `go_i` strobe together with a read/write select, a PHY address, a register address and, for a write, a data word. The block then clocks a complete frame onto the bus. It produces the management clock `mdc_o` itself and controls the shared data line through a separate output, output-enable and input. An external tristate buffer joins these three signals into the single bidirectional pin. The incoming line is synchronised into the system clock domain before the block uses it.

Every frame is built from bit slots. Each slot is a low half of `mdc_o` followed by a high half, and each half lasts `HALF_DIV` system clocks. On a read the block releases the line at the first turnaround slot and samples it. A PHY that is present pulls this bit low. If the line is still high, no PHY answered: the block sends a recovery burst of idle clocks and reports an error instead of data. In both cases `done_o` pulses once when the transaction ends.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset `mdc_o`, `mdio_oe_o`, `done_o` and `no_phy_o` are low and `rdata_o` is zero. While no transaction runs, `mdc_o` and `mdio_oe_o` stay low.
- R2: Slots 0 to 31 of every frame drive the line high (preamble), with the output enable asserted.
- R3: Slots 32 and 33 carry 0 then 1. Slots 34 and 35 carry the opcode: 1,0 for a read and 0,1 for a write.
- R4: Slots 36 to 40 carry the PHY address and slots 41 to 45 carry the register address, each most significant bit first. Both are taken from the inputs on the cycle in which `go_i` is accepted.
- R5: In every slot, `mdc_o` is low for `HALF_DIV` clocks and then high for `HALF_DIV` clocks. `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low.
- R6: A write drives 1,0 in slots 46 and 47, then the 16 data bits MSB first in slots 48 to 63. It then releases the line for one final slot: 65 clock pulses in all, with the enable asserted in the first 64.
- R7: A read drives the line only in slots 0 to 45 and releases it from slot 46 on. A read that finds a PHY lasts 65 clock pulses. The line is sampled at the end of each high half.
- R8: A read whose slot-46 sample is 1 stops capturing and adds 32 released idle slots (79 pulses in all). It ends with `no_phy_o` high and `rdata_o` unchanged.
- R9: A read whose slot-46 sample is 0 captures slots 48 to 63, MSB first, into `rdata_o` and ends with `no_phy_o` low.
- R10: `done_o` is high for exactly one system clock at the end of every transaction, whatever its outcome. `rdata_o` changes only at the end of a successful read. `no_phy_o` holds its value until the next accepted `go_i`.
- R11: A `go_i` that arrives while a transaction runs is ignored. The running frame, its length and its fields are unaffected, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start strobe; accepted only while idle |
| read_i | input | 1 | 1 selects a read, 0 a write |
| phy_addr_i | input | ADDR_W | PHY address |
| reg_addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Data from the last successful read |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| no_phy_o | output | 1 | Last transaction found no PHY |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input (asynchronous) |

## Verification
The assertions rely on two things about the inputs. First, `mdio_i` may change only while `mdc_o` is low, and then early enough that the synchronised value is settled before the end of the following high half. The configuration check `HALF_DIV > SYNC_STAGES` guarantees that margin. Second, `go_i` may arrive at any time, including while busy. The stimulus models the PHY so that it changes the line only on the cycle after `mdc_o` falls, and it raises `go_i` in the middle of running frames on purpose.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

   typedef enum logic [1:0] {
      K_IDLE  = 2'd0,
      K_WRITE = 2'd1,
      K_READ  = 2'd2,
      K_ABORT = 2'd3
   } xfer_kind_e;

   localparam logic [1:0] SOF_BITS = 2'b01;
   localparam logic [1:0] OP_RD    = 2'b10;
   localparam logic [1:0] OP_WR    = 2'b01;
   localparam logic [1:0] TA_WR    = 2'b10;

endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("mgmt_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= d_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   if (HALF_DIV < 2) begin : g_bad_div
      $error("mgmt_half_timer: HALF_DIV must be at least 2");
   end

   localparam int CW = $clog2(HALF_DIV);
   localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
   localparam bit IS_POW2 = ((1 << CW) == HALF_DIV);

   logic [CW-1:0] cnt_q;

   if (IS_POW2) begin : g_wrap
      // power of two: the counter wraps by itself, no compare on reload
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (!run_i) cnt_q <= '0;
         else             cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_reload
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt_q <= '0;
         else if (!run_i)            cnt_q <= '0;
         else if (cnt_q == CNT_LAST) cnt_q <= '0;
         else                        cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == CNT_LAST);

   // R5: two ticks are never adjacent, so every half lasts several clocks
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
   import mgmt_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_LEN  = 32,
   parameter int IDLE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              read_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              tick_i,
   input  logic              line_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              no_phy_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o
);
   if (ADDR_W < 1 || DATA_W < 2 || PRE_LEN < 1 || IDLE_LEN < 1) begin : g_bad_cfg
      $error("mgmt_frame_seq: illegal field length");
   end

   localparam int HDR_LEN  = PRE_LEN + 4 + 2 * ADDR_W;   // slots driven in every frame
   localparam int TX_LEN   = HDR_LEN + 2 + DATA_W;       // slots driven by a write
   localparam int DAT0     = HDR_LEN + 2;                // first data slot
   localparam int LAST_OK  = TX_LEN;                     // trailing released slot
   localparam int LAST_ERR = HDR_LEN + IDLE_LEN;         // end of recovery burst
   localparam int LAST_MAX = (LAST_ERR > LAST_OK) ? LAST_ERR : LAST_OK;
   localparam int SLOT_W   = $clog2(LAST_MAX + 1);

   localparam logic [SLOT_W-1:0] S_HDR  = SLOT_W'(HDR_LEN);
   localparam logic [SLOT_W-1:0] S_TX   = SLOT_W'(TX_LEN);
   localparam logic [SLOT_W-1:0] S_DAT0 = SLOT_W'(DAT0);
   localparam logic [SLOT_W-1:0] S_LOK  = SLOT_W'(LAST_OK);
   localparam logic [SLOT_W-1:0] S_LERR = SLOT_W'(LAST_ERR);

   logic              busy_q, hi_q, done_q, err_q, dout_q, oe_q;
   logic [SLOT_W-1:0] slot_q;
   xfer_kind_e        kind_q;
   logic [TX_LEN-1:0] tx_sh_q;
   logic [DATA_W-1:0] rd_sh_q, rdata_q;

   logic              end_hi, abort_now, finish, oe_nx, capture;
   xfer_kind_e        kind_nx;
   logic [SLOT_W-1:0] slot_nx;
   logic [TX_LEN-1:0] new_frame;

   assign new_frame = {{PRE_LEN{1'b1}}, SOF_BITS, (read_i ? OP_RD : OP_WR),
                       phy_addr_i, reg_addr_i, TA_WR, wdata_i};

   always_comb begin
      end_hi    = busy_q && tick_i && hi_q;
      abort_now = end_hi && (kind_q == K_READ) && (slot_q == S_HDR) && line_i;
      kind_nx   = abort_now ? K_ABORT : kind_q;
      finish    = end_hi && (slot_q == ((kind_nx == K_ABORT) ? S_LERR : S_LOK));
      slot_nx   = slot_q + 1'b1;
      unique case (kind_nx)
         K_WRITE: oe_nx = (slot_nx < S_TX);
         K_READ:  oe_nx = (slot_nx < S_HDR);
         default: oe_nx = 1'b0;
      endcase
      capture   = end_hi && (kind_q == K_READ) && (slot_q >= S_DAT0) && (slot_q < S_TX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         hi_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         dout_q  <= 1'b1;
         oe_q    <= 1'b0;
         slot_q  <= '0;
         kind_q  <= K_IDLE;
         tx_sh_q <= '0;
         rd_sh_q <= '0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (go_i) begin
               busy_q  <= 1'b1;
               hi_q    <= 1'b0;
               slot_q  <= '0;
               err_q   <= 1'b0;
               kind_q  <= read_i ? K_READ : K_WRITE;
               dout_q  <= new_frame[TX_LEN-1];
               tx_sh_q <= new_frame << 1;
               oe_q    <= 1'b1;
            end
         end else if (tick_i) begin
            if (!hi_q) begin
               hi_q <= 1'b1;
            end else begin
               hi_q <= 1'b0;
               if (capture) rd_sh_q <= {rd_sh_q[DATA_W-2:0], line_i};
               if (finish) begin
                  busy_q <= 1'b0;
                  oe_q   <= 1'b0;
                  done_q <= 1'b1;
                  kind_q <= K_IDLE;
                  if (kind_nx == K_ABORT)    err_q   <= 1'b1;
                  else if (kind_q == K_READ) rdata_q <= rd_sh_q;
               end else begin
                  slot_q  <= slot_nx;
                  kind_q  <= kind_nx;
                  oe_q    <= oe_nx;
                  dout_q  <= oe_nx ? tx_sh_q[TX_LEN-1] : 1'b1;
                  tx_sh_q <= tx_sh_q << 1;
               end
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign rdata_o   = rdata_q;
   assign done_o    = done_q;
   assign no_phy_o  = err_q;
   assign mdc_o     = hi_q;
   assign mdio_o    = dout_q;
   assign mdio_oe_o = oe_q;

   // R1: an idle bus keeps the clock low and the line released
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!hi_q && !oe_q));

   // R5: line value and enable hold across a high half of the clock
   p_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_q && $past(hi_q)) |-> ($stable(dout_q) && $stable(oe_q)));

   // R10: the completion strobe lasts a single clock
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R8: the absence flag only rises at the end of an aborted read
   p_err_after_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> ($past(kind_q) == K_ABORT && done_q));

   // R11: a strobe while busy never restarts the slot count
   p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && go_i && !finish) |=> (busy_q && (slot_q >= $past(slot_q))));
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 16,
   parameter int PRE_LEN     = 32,
   parameter int IDLE_LEN    = 32,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              read_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              no_phy_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);
   if (HALF_DIV <= SYNC_STAGES) begin : g_bad_margin
      $error("mgmt_serial_master: HALF_DIV must exceed SYNC_STAGES");
   end

   logic busy, tick, line_s;

   mgmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (mdio_i),
      .q_o   (line_s)
   );

   mgmt_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy),
      .tick_o (tick)
   );

   mgmt_frame_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PRE_LEN  (PRE_LEN),
      .IDLE_LEN (IDLE_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go_i),
      .read_i     (read_i),
      .phy_addr_i (phy_addr_i),
      .reg_addr_i (reg_addr_i),
      .wdata_i    (wdata_i),
      .tick_i     (tick),
      .line_i     (line_s),
      .busy_o     (busy),
      .rdata_o    (rdata_o),
      .done_o     (done_o),
      .no_phy_o   (no_phy_o),
      .mdc_o      (mdc_o),
      .mdio_o     (mdio_o),
      .mdio_oe_o  (mdio_oe_o)
   );
endmodule

// File: tb/mgmt_serial_master_bench.sv
`timescale 1ns/1ps
module mgmt_serial_master_bench;
   localparam int HALF = 4;
   localparam int HDR  = 46;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0, rd = 1'b0;
   logic [4:0]  pa = '0, ra = '0;
   logic [15:0] wd = '0;
   logic [15:0] rdata;
   logic        done, no_phy, mdc, mdo, moe;
   logic        mdi = 1'b1;

   always #2.5 clk = ~clk;

   mgmt_serial_master #(.HALF_DIV(HALF), .SYNC_STAGES(2)) u_mgmt_serial_master (
      .clk(clk), .rst_n(rst_n), .go_i(go), .read_i(rd), .phy_addr_i(pa),
      .reg_addr_i(ra), .wdata_i(wd), .rdata_o(rdata), .done_o(done),
      .no_phy_o(no_phy), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi));

   int n_chk = 0, n_err = 0;
   int rises = 0, done_cnt = 0, bad_half = 0, bad_stable = 0, ph_len = 0;
   logic [127:0] olog, elog;
   logic mdc_p = 1'b0, mdo_p = 1'b1, moe_p = 1'b0;
   logic ph_present = 1'b1;
   logic [15:0] ph_data = '0;
   logic [15:0] prev_rdata = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bus monitor and PHY model
   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc && !mdc_p) begin
            olog[rises] = mdo;
            elog[rises] = moe;
            if (rises != 0 && ph_len != HALF) bad_half++;
            rises++;
            ph_len = 1;
         end else if (!mdc && mdc_p) begin
            if (ph_len != HALF) bad_half++;
            ph_len = 1;
            if (rises == HDR)                        mdi = !ph_present;
            else if (rises == HDR + 1)               mdi = !ph_present;
            else if (rises >= HDR + 2 && rises < HDR + 18)
               mdi = ph_data[15 - (rises - HDR - 2)];
            else                                     mdi = 1'b1;
         end else begin
            ph_len++;
         end
         if (mdc && mdc_p && (mdo != mdo_p || moe != moe_p)) bad_stable++;
         if (done) done_cnt++;
      end
      mdc_p = mdc; mdo_p = mdo; moe_p = moe;
   end

   task automatic txn(input bit r, input logic [4:0] a, input logic [4:0] g,
                      input logic [15:0] w, input bit present,
                      input logic [15:0] pdata, input int poke);
      logic [63:0] fr;
      int exp_rises, n_oe, cyc, m_pre, m_sof, m_adr, m_dat, m_oe, r_snap;
      @(negedge clk); #1;
      rises = 0; done_cnt = 0; bad_half = 0; bad_stable = 0;
      ph_present = present; ph_data = pdata;
      rd = r; pa = a; ra = g; wd = w; go = 1'b1;
      @(negedge clk); #1;
      go = 1'b0; pa = ~a; ra = ~g; wd = ~w; rd = !r;   // fields must already be held
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk); #1;
         cyc++;
         go = (poke > 0 && cyc == poke);
      end
      go = 1'b0;
      @(negedge clk); #1;
      chk(!done, "R10", "done width", done, 0);
      r_snap = rises;
      repeat (40) @(negedge clk);
      #1;
      mdi = 1'b1;
      exp_rises = (r && !present) ? 79 : 65;
      n_oe = r ? HDR : 64;
      fr = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), a, g, 2'b10, w};
      m_pre = 0; m_sof = 0; m_adr = 0; m_dat = 0; m_oe = 0;
      for (int i = 0; i < n_oe; i++) begin
         if (olog[i] != fr[63-i]) begin
            if (i < 32)      m_pre++;
            else if (i < 36) m_sof++;
            else if (i < 46) m_adr++;
            else             m_dat++;
         end
      end
      for (int i = 0; i < rises && i < 128; i++)
         if (elog[i] != (i < n_oe)) m_oe++;
      chk(rises == exp_rises, r ? (present ? "R7" : "R8") : "R6", "mdc pulses", rises, exp_rises);
      chk(m_pre == 0, "R2", "preamble bit errors", m_pre, 0);
      chk(m_sof == 0, "R3", "start/opcode bit errors", m_sof, 0);
      chk(m_adr == 0, "R4", "address bit errors", m_adr, 0);
      if (!r) chk(m_dat == 0, "R6", "turnaround/data bit errors", m_dat, 0);
      chk(m_oe == 0, r ? "R7" : "R6", "enable pattern errors", m_oe, 0);
      chk(bad_half == 0, "R5", "half period errors", bad_half, 0);
      chk(bad_stable == 0, "R5", "change while clock high", bad_stable, 0);
      chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
      if (poke > 0) chk(r_snap == rises && rises == exp_rises, "R11", "activity after strobe while busy", rises, r_snap);
      if (r && present) begin
         chk(rdata == pdata, "R9", "read data", rdata, pdata);
         chk(!no_phy, "R9", "absence flag", no_phy, 0);
         prev_rdata = pdata;
      end else if (r) begin
         chk(no_phy, "R8", "absence flag", no_phy, 1);
         chk(rdata == prev_rdata, "R8", "read data kept", rdata, prev_rdata);
      end else begin
         chk(!no_phy, "R10", "absence flag after write", no_phy, 0);
         chk(rdata == prev_rdata, "R10", "read data kept by write", rdata, prev_rdata);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: quiet after reset
      chk(!mdc && !moe, "R1", "clock/enable after reset", {mdc, moe}, 0);
      chk(!done && !no_phy, "R1", "flags after reset", {done, no_phy}, 0);
      chk(rdata == 0, "R1", "read data after reset", rdata, 0);
      repeat (10) @(negedge clk);
      #1;
      chk(!mdc && !moe, "R1", "idle bus", {mdc, moe}, 0);

      for (int i = 0; i < 32; i++)
         txn(1'b0, 5'(i), 5'(31 - i), 16'((i * 16'h0841) ^ 16'hA5C3), 1'b1, '0, 0);
      for (int i = 0; i < 16; i++)
         txn(1'b1, 5'(i * 3), 5'(i * 5 + 1), '0, 1'b1, 16'((16'h1 << i) ^ (i * 16'h1357)), 0);
      txn(1'b1, 5'h1F, 5'h00, '0, 1'b1, 16'hFFFF, 0);
      txn(1'b1, 5'h00, 5'h1F, '0, 1'b1, 16'h0000, 0);
      txn(1'b1, 5'h0A, 5'h15, '0, 1'b1, 16'hBEEF, 0);
      txn(1'b1, 5'h11, 5'h02, '0, 1'b0, 16'h1234, 0);   // no PHY
      txn(1'b0, 5'h05, 5'h06, 16'h8001, 1'b1, '0, 0);
      txn(1'b1, 5'h1E, 5'h0C, '0, 1'b0, '0, 0);         // no PHY again
      txn(1'b1, 5'h03, 5'h04, '0, 1'b1, 16'h5AA5, 0);
      txn(1'b0, 5'h12, 5'h09, 16'hC3A5, 1'b1, '0, 100); // strobe while busy
      txn(1'b1, 5'h07, 5'h1B, '0, 1'b1, 16'h0F0F, 300);
      txn(1'b1, 5'h08, 5'h01, '0, 1'b0, '0, 500);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule